// File: doc/BRIEF.md
# Tagged Memory Lock-and-Key Checker

This block protects a small on-chip data memory. The memory is split into 16-byte granules, and each granule has one 4-bit tag that acts as a lock. Every request carries a 64-bit pointer. Four bits of the pointer's top byte are the key for that access. The block drops the whole top byte when it forms the memory location, so the key never changes which word is reached.

A load or store goes ahead only when the key equals the tag of the addressed granule. On a mismatch the access is suppressed, and a one-cycle fault pulse reports the pointer and whether the access was a store.

A second group of operations maintains the locks, and none of them is ever checked against the current tag:
- set the tag of one granule, leaving its data alone;
- set the tag and clear the granule's data;
- set the same tag on a granule and the one after it, with or without clearing;
- read back a granule's tag.

Requests are accepted on any cycle. Results appear one clock after the request is sampled.

Top module: `tag_guard`

## Requirements
- R1: After reset every tag and every data word is zero. A load with key 0 then completes without a fault, and a tag read returns 0.
- R2: Pointer bits 63:60 affect neither the location nor the tag comparison. Bits 63:56 never select the location. The granule index is bits 4 upward, truncated to the memory depth, and the 32-bit word within the granule is bits 3:2.
- R3: A load (op 0) whose key (bits 59:56) equals the granule tag raises rspValid one cycle later, with the addressed word on rspData.
- R4: A load whose key differs from the tag gives no rspValid. One cycle later faultValid pulses for exactly one cycle, with faultAddr equal to the pointer and faultIsStore low.
- R5: A store (op 1) with a matching key writes reqWdata to the addressed word. A store with a mismatching key leaves memory unchanged and pulses faultValid with faultIsStore high. Stores never raise rspValid.
- R6: A tag set (op 2) writes the key into the addressed granule's tag and leaves its data unchanged.
- R7: A zeroing tag set (op 3) writes the tag and also clears every word of that granule.
- R8: A dual tag set (op 4 without clearing, op 5 with clearing) applies the same key as the tag of granule g and granule g+1. The granule after the last one wraps to granule 0.
- R9: A tag read (op 6) raises rspValid one cycle later, with the tag in rspData[3:0] and the upper bits of rspData zero.
- R10: Tag operations (ops 2 to 6) never fault, whatever the key and the stored tag.
- R11: Op 7 changes no tag and no data, and produces neither a response nor a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqOp | input | 3 | Operation code (see R3 to R11) |
| reqAddr | input | 64 | Pointer; key in bits 59:56 |
| reqWdata | input | 32 | Store data |
| rspValid | output | 1 | Read result valid |
| rspData | output | 32 | Loaded word or tag |
| faultValid | output | 1 | One-cycle tag-mismatch pulse |
| faultAddr | output | 64 | Pointer of the faulting access |
| faultIsStore | output | 1 | Faulting access was a store |

## Verification
The bench targets these corner cases:
- **Mismatched store.** A later load of that word must still read the old value. A design that fails to gate the write enable would show the blocked data.
- **Zeroing tag set with a wrong key.** The operation uses a key that differs from the current tag. A design that checks tag operations would fault here instead of clearing.
- **Dual set on the last granule.** The second tag must land on granule 0. An index that fails to wrap would leave granule 0 locked with its old tag.
- **Junk in pointer bits 63:60.** Loads and stores with junk in these bits must still reach the same word and pass the check. A design that compares or indexes with the wrong bits would miss the word or fault spuriously.
- **Fault duration.** The fault must fall again after one cycle; a sticky fault would stay high.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;

  localparam int PTR_W   = 64;
  localparam int KEY_W   = 4;
  localparam int KEY_LSB = 56;
  localparam int GRAN_LSB = 4;   // 16-byte granule

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_TAGSET   = 3'd2,
    OP_TAGSETZ  = 3'd3,
    OP_TAGSET2  = 3'd4,
    OP_TAGSET2Z = 3'd5,
    OP_TAGREAD  = 3'd6,
    OP_NONE     = 3'd7
  } opE;

  typedef struct packed {
    logic wrWord;     // write addressed data word
    logic rdWord;     // return addressed data word
    logic rdTag;      // return addressed granule tag
    logic wrTag;      // write tag of addressed granule
    logic wrTagNext;  // write tag of following granule
    logic zeroCur;    // clear addressed granule data
    logic zeroNext;   // clear following granule data
  } strobeT;

endpackage

// File: rtl/tag_guard_ctrl.sv
module tag_guard_ctrl
  import tag_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqOp,
  input  logic [PTR_W-1:0]   reqAddr,
  input  logic [KEY_W-1:0]   curTag,
  output strobeT             stb,
  output logic               faultValid,
  output logic [PTR_W-1:0]   faultAddr,
  output logic               faultIsStore
);

  logic [KEY_W-1:0] reqKey;
  logic             isLoad;
  logic             isStore;
  logic             keyHit;
  logic             isTagOp;

  assign reqKey  = reqAddr[KEY_LSB +: KEY_W];
  assign isLoad  = reqValid && (opE'(reqOp) == OP_LOAD);
  assign isStore = reqValid && (opE'(reqOp) == OP_STORE);
  assign isTagOp = reqValid && (reqOp >= 3'd2) && (reqOp <= 3'd6);
  assign keyHit  = (reqKey == curTag);

  always_comb begin
    stb = '0;
    if (reqValid) begin
      unique case (opE'(reqOp))
        OP_LOAD:     stb.rdWord = keyHit;
        OP_STORE:    stb.wrWord = keyHit;
        OP_TAGSET:   stb.wrTag  = 1'b1;
        OP_TAGSETZ: begin
          stb.wrTag   = 1'b1;
          stb.zeroCur = 1'b1;
        end
        OP_TAGSET2: begin
          stb.wrTag     = 1'b1;
          stb.wrTagNext = 1'b1;
        end
        OP_TAGSET2Z: begin
          stb.wrTag     = 1'b1;
          stb.wrTagNext = 1'b1;
          stb.zeroCur   = 1'b1;
          stb.zeroNext  = 1'b1;
        end
        OP_TAGREAD:  stb.rdTag = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultValid   <= 1'b0;
      faultAddr    <= '0;
      faultIsStore <= 1'b0;
    end else begin
      faultValid <= (isLoad || isStore) && !keyHit;
      if ((isLoad || isStore) && !keyHit) begin
        faultAddr    <= reqAddr;
        faultIsStore <= isStore;
      end
    end
  end

  AST_MISMATCH_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    ((isLoad || isStore) && (reqKey != curTag)) |=> faultValid) else $error("mismatch without fault"); // R4

  AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ((isLoad || isStore) && (reqKey == curTag)) |=> !faultValid) else $error("fault on matching key"); // R3

  AST_TAGOP_UNCHECKED: assert property (@(posedge clk) disable iff (!rstN)
    isTagOp |=> !faultValid) else $error("tag operation faulted"); // R10

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ((isLoad || isStore) && (reqKey != curTag)) |=> (faultAddr == $past(reqAddr))) else $error("fault address wrong"); // R4

endmodule

// File: rtl/tag_guard_datapath.sv
module tag_guard_datapath
  import tag_guard_pkg::*;
#(
  parameter int GRAN_CNT = 16,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PTR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  strobeT             stb,
  output logic [KEY_W-1:0]   curTag,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData
);

  localparam int WPG      = 128 / DATA_W;
  localparam int WSEL_W   = $clog2(WPG);
  localparam int BYTE_W   = $clog2(DATA_W / 8);
  localparam int IDX_W    = $clog2(GRAN_CNT);
  localparam int WORD_CNT = GRAN_CNT * WPG;
  localparam int FLAT_W   = IDX_W + WSEL_W;

  logic [KEY_W-1:0]  tagMem  [GRAN_CNT];
  logic [DATA_W-1:0] dataMem [WORD_CNT];

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [WSEL_W-1:0] wordSel;
  logic [FLAT_W-1:0] flatIdx;
  logic [KEY_W-1:0]  newTag;

  assign curIdx  = reqAddr[GRAN_LSB +: IDX_W];
  assign nextIdx = curIdx + 1'b1;
  assign wordSel = reqAddr[BYTE_W +: WSEL_W];
  assign flatIdx = {curIdx, wordSel};
  assign newTag  = reqAddr[KEY_LSB +: KEY_W];
  assign curTag  = tagMem[curIdx];

  // Tag store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < GRAN_CNT; g++) tagMem[g] <= '0;
    end else begin
      if (stb.wrTag)     tagMem[curIdx]  <= newTag;
      if (stb.wrTagNext) tagMem[nextIdx] <= newTag;
    end
  end

  // Data store, one writer per word
  for (genvar gi = 0; gi < GRAN_CNT; gi++) begin : g_gran
    for (genvar wi = 0; wi < WPG; wi++) begin : g_word
      localparam int FLAT = gi * WPG + wi;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dataMem[FLAT] <= '0;
        end else if ((stb.zeroCur && curIdx == IDX_W'(gi)) ||
                     (stb.zeroNext && nextIdx == IDX_W'(gi))) begin
          dataMem[FLAT] <= '0;
        end else if (stb.wrWord && flatIdx == FLAT_W'(FLAT)) begin
          dataMem[FLAT] <= reqWdata;
        end
      end
    end
  end

  // Response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= stb.rdWord || stb.rdTag;
      if (stb.rdTag)       rspData <= DATA_W'(curTag);
      else if (stb.rdWord) rspData <= dataMem[flatIdx];
    end
  end

  AST_ZERO_WITH_TAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroCur |-> stb.wrTag) else $error("clear without tag write"); // R7

  AST_PAIR_WITH_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrTagNext || stb.zeroNext) |-> stb.wrTag) else $error("pair without first tag"); // R8

  AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(stb.rdWord || stb.rdTag)) else $error("response without read"); // R3

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrWord, stb.rdWord, stb.rdTag, stb.wrTag})) else $error("conflicting strobes"); // R11

endmodule

// File: rtl/tag_guard.sv
module tag_guard
  import tag_guard_pkg::*;
#(
  parameter int GRAN_CNT = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [63:0]       reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              faultValid,
  output logic [63:0]       faultAddr,
  output logic              faultIsStore
);

  strobeT           stb;
  logic [KEY_W-1:0] curTag;

  tag_guard_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqAddr      (reqAddr),
    .curTag       (curTag),
    .stb          (stb),
    .faultValid   (faultValid),
    .faultAddr    (faultAddr),
    .faultIsStore (faultIsStore)
  );

  tag_guard_datapath #(
    .GRAN_CNT (GRAN_CNT),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .stb      (stb),
    .curTag   (curTag),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  AST_FAULT_XOR_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !(faultValid && rspValid)) else $error("fault and response together"); // R4

endmodule

// File: tb/tag_guard_tb.sv
module tag_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 28;

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] addr;
    logic [31:0] wdata;
    logic        expRsp;
    logic [31:0] expData;
    logic        expFault;
    logic [31:0] reqTag;
  } vecT;

  function automatic logic [63:0] mkA(input logic [3:0] junk, input logic [3:0] key,
                                      input int g, input int w);
    logic [63:0] a;
    a = '0;
    a[63:60] = junk;
    a[59:56] = key;
    a[7:4]   = 4'(g);
    a[3:2]   = 2'(w);
    return a;
  endfunction

  localparam vecT VECS [N_VEC] = '{
    '{3'd1, mkA(4'h0, 4'h0, 1, 0), 32'h11111111, 1'b0, 32'h0,        1'b0, "R5"},
    '{3'd0, mkA(4'h0, 4'h0, 1, 0), 32'h0,        1'b1, 32'h11111111, 1'b0, "R3"},
    '{3'd2, mkA(4'h0, 4'h5, 1, 0), 32'h0,        1'b0, 32'h0,        1'b0, "R6"},
    '{3'd0, mkA(4'h0, 4'h5, 1, 0), 32'h0,        1'b1, 32'h11111111, 1'b0, "R6"},
    '{3'd0, mkA(4'h0, 4'h0, 1, 0), 32'h0,        1'b0, 32'h0,        1'b1, "R4"},
    '{3'd1, mkA(4'h0, 4'h3, 1, 1), 32'hDEADBEEF, 1'b0, 32'h0,        1'b1, "R5"},
    '{3'd0, mkA(4'h0, 4'h5, 1, 1), 32'h0,        1'b1, 32'h0,        1'b0, "R5"},
    '{3'd6, mkA(4'h0, 4'h0, 1, 0), 32'h0,        1'b1, 32'h5,        1'b0, "R9"},
    '{3'd1, mkA(4'h0, 4'h5, 1, 2), 32'hCAFEF00D, 1'b0, 32'h0,        1'b0, "R5"},
    '{3'd0, mkA(4'h0, 4'h5, 1, 2), 32'h0,        1'b1, 32'hCAFEF00D, 1'b0, "R3"},
    '{3'd3, mkA(4'h0, 4'h9, 1, 0), 32'h0,        1'b0, 32'h0,        1'b0, "R10"},
    '{3'd0, mkA(4'h0, 4'h9, 1, 2), 32'h0,        1'b1, 32'h0,        1'b0, "R7"},
    '{3'd0, mkA(4'h0, 4'h9, 1, 0), 32'h0,        1'b1, 32'h0,        1'b0, "R7"},
    '{3'd1, mkA(4'h0, 4'h0, 15, 3), 32'hABCD0123, 1'b0, 32'h0,       1'b0, "R5"},
    '{3'd1, mkA(4'h0, 4'h0, 0, 0), 32'h12340000, 1'b0, 32'h0,        1'b0, "R5"},
    '{3'd4, mkA(4'h0, 4'hA, 15, 0), 32'h0,       1'b0, 32'h0,        1'b0, "R8"},
    '{3'd0, mkA(4'h0, 4'hA, 15, 3), 32'h0,       1'b1, 32'hABCD0123, 1'b0, "R8"},
    '{3'd0, mkA(4'h0, 4'hA, 0, 0), 32'h0,        1'b1, 32'h12340000, 1'b0, "R8"},
    '{3'd1, mkA(4'h0, 4'h0, 3, 0), 32'h77777777, 1'b0, 32'h0,        1'b0, "R5"},
    '{3'd5, mkA(4'h0, 4'hC, 2, 0), 32'h0,        1'b0, 32'h0,        1'b0, "R8"},
    '{3'd0, mkA(4'h0, 4'hC, 3, 0), 32'h0,        1'b1, 32'h0,        1'b0, "R8"},
    '{3'd6, mkA(4'h0, 4'h0, 2, 0), 32'h0,        1'b1, 32'hC,        1'b0, "R9"},
    '{3'd7, mkA(4'h0, 4'h6, 4, 0), 32'h0,        1'b0, 32'h0,        1'b0, "R11"},
    '{3'd6, mkA(4'h0, 4'h0, 4, 0), 32'h0,        1'b1, 32'h0,        1'b0, "R11"},
    '{3'd0, mkA(4'hF, 4'hA, 15, 3), 32'h0,       1'b1, 32'hABCD0123, 1'b0, "R2"},
    '{3'd1, mkA(4'h9, 4'h0, 4, 1), 32'h55AA55AA, 1'b0, 32'h0,        1'b0, "R2"},
    '{3'd0, mkA(4'h0, 4'h0, 4, 1), 32'h0,        1'b1, 32'h55AA55AA, 1'b0, "R2"},
    '{3'd0, mkA(4'h3, 4'hC, 2, 0), 32'h0,        1'b1, 32'h0,        1'b0, "R7"}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [63:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        faultValid;
  logic [63:0] faultAddr;
  logic        faultIsStore;

  int nApplied = 0;
  int nFail    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tag_guard u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .rspValid     (rspValid),
    .rspData      (rspData),
    .faultValid   (faultValid),
    .faultAddr    (faultAddr),
    .faultIsStore (faultIsStore)
  );

  task automatic chk(input logic [31:0] tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nApplied++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, sample one clock later at the next falling edge.
  task automatic doReq(input vecT v);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = v.op;
    reqAddr  = v.addr;
    reqWdata = v.wdata;
    @(negedge clk);
    reqValid = 1'b0;
    chk(v.reqTag, "rspValid", 64'(rspValid), 64'(v.expRsp));
    if (v.expRsp) chk(v.reqTag, "rspData", 64'(rspData), 64'(v.expData));
    chk(v.reqTag, "faultValid", 64'(faultValid), 64'(v.expFault));
    if (v.expFault) begin
      chk(v.reqTag, "faultAddr", faultAddr, v.addr);
      chk(v.reqTag, "faultIsStore", 64'(faultIsStore), 64'(v.op == 3'd1));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "faultValid", 64'(faultValid), 64'd0);
    // R1: tags start at zero, key 0 load passes and reads zero
    doReq('{3'd6, mkA(4'h0, 4'h0, 7, 0), 32'h0, 1'b1, 32'h0, 1'b0, "R1"});
    doReq('{3'd0, mkA(4'h0, 4'h0, 7, 2), 32'h0, 1'b1, 32'h0, 1'b0, "R1"});

    for (int i = 0; i < N_VEC; i++) doReq(VECS[i]);

    // R4: fault is a single-cycle pulse
    doReq('{3'd0, mkA(4'h0, 4'h1, 7, 0), 32'h0, 1'b0, 32'h0, 1'b1, "R4"});
    @(negedge clk);
    chk("R4", "faultValid after pulse", 64'(faultValid), 64'd0);

    // R5: store fault reports store type; back-to-back faults
    doReq('{3'd1, mkA(4'h0, 4'h2, 7, 1), 32'h13572468, 1'b0, 32'h0, 1'b1, "R5"});
    doReq('{3'd0, mkA(4'h0, 4'h0, 7, 1), 32'h0, 1'b1, 32'h0, 1'b0, "R5"});

    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end

endmodule